// File: doc/BRIEF.md
# Dual-Input Cascadable Up/Down Counter

This block is a reversible binary counter, four bits wide by default, that steps on two separate count lines. A rising edge on the up line adds one and a rising edge on the down line takes one away. The line not in use is held high. An active-low preset strobe copies a parallel data word into the count. An active-high clear zeroes the count and wins over everything else.

The block runs on a single system clock. Each count line passes through a synchronizer and an edge detector, and the flops are never clocked from the count lines. All count bits change together on one clock edge. The borrow and carry outputs are active low. Each one is gated by the level of its own count line, so it forms a low pulse that ends when that line returns high. A stage can therefore drive the next stage's down and up lines directly, and a chain of stages behaves as one wider counter.

Top module: `ud_cascade_counter`

## Requirements
- R1: A 0-to-1 change on `upIn` adds exactly one to `count`. With the default two synchronizer stages, `count` changes on the third rising `clk` edge at which the new high level is present.
- R2: A 0-to-1 change on `downIn` subtracts exactly one from `count`, with the same latency as R1.
- R3: Counting wraps modulo 2^WIDTH: stepping up from all ones gives zero, and stepping down from zero gives all ones.
- R4: On every `clk` edge at which `loadN` is 0, `count` takes `dataIn`. A count edge that falls due on such an edge is dropped.
- R5: While `clear` is 1, `count` is zero at once, without waiting for a clock edge, whatever `loadN`, `upIn` and `downIn` do.
- R6: `borrowN` is 0 exactly when `count` is zero and `downIn` is 0. Otherwise it is 1.
- R7: `carryN` is 0 exactly when `count` is all ones and `upIn` is 0. Otherwise it is 1.
- R8: When rising edges on `upIn` and `downIn` fall due on the same clock edge, `count` does not change.
- R9: Two instances form an 8-bit counter when the low stage's `carryN` drives the high stage's `upIn` and its `borrowN` drives the high stage's `downIn`, with `loadN` and `clear` shared. `{high count, low count}` then follows every up, down, preset and clear.
- R10: A count line that stays at one level, high or low, for any number of cycles causes no further step. Each rising edge gives one step only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| upIn | input | 1 | Count-up line; its rising edges add one |
| downIn | input | 1 | Count-down line; its rising edges subtract one |
| loadN | input | 1 | Active-low preset strobe |
| dataIn | input | WIDTH | Preset value |
| clear | input | 1 | Active-high asynchronous clear |
| count | output | WIDTH | Current count |
| borrowN | output | 1 | Low while count is zero and downIn is low |
| carryN | output | 1 | Low while count is all ones and upIn is low |

## Verification
A wrong synchronizer or edge-detector state shows up at the ports as a missed step, a doubled step or a step one cycle late. The per-cycle comparison of the chained 8-bit value catches each of these within three clock edges of the count-line change. A wrong count value also corrupts `borrowN` and `carryN` while the matching count line is low. Through the chain it then moves the high nibble on the next pulse, so a wrap error at the low stage shows as a 16-count jump in the combined value.

// File: rtl/ud_pkg.sv
package ud_pkg;
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } stepCtl_t;
endpackage

// File: rtl/ud_edge_sense.sv
module ud_edge_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic rawIn,
  output logic rise
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or posedge clear) begin
        if (clear) syncQ <= '1;
        else       syncQ <= rawIn;
      end
    end else begin : gChain
      always_ff @(posedge clk or posedge clear) begin
        if (clear) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge clear) begin
    if (clear) prevQ <= 1'b1;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~prevQ;

  AST_RISE_ONE_SHOT: assert property (@(posedge clk) disable iff (clear)
    rise |=> !rise); // R10
endmodule

// File: rtl/ud_control.sv
module ud_control
  import ud_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     clear,
  input  logic     upIn,
  input  logic     downIn,
  input  logic     loadN,
  output stepCtl_t ctl
);
  logic upRise;
  logic downRise;

  ud_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) upSense (
    .clk(clk), .clear(clear), .rawIn(upIn), .rise(upRise)
  );
  ud_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) downSense (
    .clk(clk), .clear(clear), .rawIn(downIn), .rise(downRise)
  );

  always_comb begin
    ctl.load = ~loadN;
    ctl.inc  = upRise & ~downRise;
    ctl.dec  = downRise & ~upRise;
  end

  AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (clear)
    !(ctl.inc && ctl.dec)); // R8
endmodule

// File: rtl/ud_datapath.sv
module ud_datapath
  import ud_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  stepCtl_t         ctl,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             upIn,
  input  logic             downIn,
  output logic [WIDTH-1:0] count,
  output logic             borrowN,
  output logic             carryN
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOP = '1;

  always_ff @(posedge clk or posedge clear) begin
    if (clear)         count <= '0;
    else if (ctl.load) count <= dataIn;
    else if (ctl.inc)  count <= count + ONE;
    else if (ctl.dec)  count <= count - ONE;
  end

  assign borrowN = ~((count == '0) & ~downIn);
  assign carryN  = ~((count == TOP) & ~upIn);

  AST_UP_STEP: assert property (@(posedge clk) disable iff (clear)
    (ctl.inc && !ctl.load) |=> count == WIDTH'($past(count) + ONE)); // R1
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (clear)
    (ctl.dec && !ctl.load) |=> count == WIDTH'($past(count) - ONE)); // R2
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (clear)
    (ctl.inc && !ctl.load && count == TOP) |=> count == '0); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (clear)
    ctl.load |=> count == $past(dataIn)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk)
    clear |-> count == '0); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clear)
    (!ctl.load && !ctl.inc && !ctl.dec) |=> $stable(count)); // R10
endmodule

// File: rtl/ud_cascade_counter.sv
module ud_cascade_counter
  import ud_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             upIn,
  input  logic             downIn,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             clear,
  output logic [WIDTH-1:0] count,
  output logic             borrowN,
  output logic             carryN
);
  stepCtl_t ctl;

  ud_control #(.SYNC_STAGES(SYNC_STAGES)) control (
    .clk(clk), .clear(clear), .upIn(upIn), .downIn(downIn),
    .loadN(loadN), .ctl(ctl)
  );

  ud_datapath #(.WIDTH(WIDTH)) datapath (
    .clk(clk), .clear(clear), .ctl(ctl), .dataIn(dataIn),
    .upIn(upIn), .downIn(downIn), .count(count),
    .borrowN(borrowN), .carryN(carryN)
  );
endmodule

// File: tb/tb_ud_cascade_counter.sv
module tb_ud_cascade_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic upIn = 1'b1, downIn = 1'b1, loadN = 1'b1, clear = 1'b1;
  logic [7:0] dataByte = 8'h00;
  logic [3:0] loCount, hiCount;
  logic loBorrowN, loCarryN, hiBorrowN, hiCarryN;

  int checks = 0, fails = 0;
  bit armed = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ud_cascade_counter dut (
    .clk(clk), .upIn(upIn), .downIn(downIn), .loadN(loadN),
    .dataIn(dataByte[3:0]), .clear(clear), .count(loCount),
    .borrowN(loBorrowN), .carryN(loCarryN)
  );
  ud_cascade_counter hiStage (
    .clk(clk), .upIn(loCarryN), .downIn(loBorrowN), .loadN(loadN),
    .dataIn(dataByte[7:4]), .clear(clear), .count(hiCount),
    .borrowN(hiBorrowN), .carryN(hiCarryN)
  );

  // Behavioural reference: 8-bit value, count-line history by clock edge.
  int model = 0;
  bit upH[1:3];
  bit dnH[1:3];

  always @(posedge clk or posedge clear) begin
    if (clear) begin
      model = 0;
      for (int i = 1; i <= 3; i++) begin upH[i] = 1'b1; dnH[i] = 1'b1; end
    end else begin
      bit upEv, dnEv;
      upEv = upH[2] && !upH[3];
      dnEv = dnH[2] && !dnH[3];
      if (!loadN) model = dataByte;
      else if (upEv && !dnEv) model = (model + 1) % 256;
      else if (dnEv && !upEv) model = (model + 255) % 256;
      else if (upEv && dnEv) begin
        if (model % 16 == 15) model = (model + 16) % 256;
        else if (model % 16 == 0) model = (model + 240) % 256;
      end
      upH[3] = upH[2]; upH[2] = upH[1]; upH[1] = upIn;
      dnH[3] = dnH[2]; dnH[2] = dnH[1]; dnH[1] = downIn;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison, sampled after inputs settle on the falling edge.
  always @(negedge clk) begin
    #1;
    if (armed && !done) begin
      int act;
      bit eb, ec;
      act = {hiCount, loCount};
      check(act == model, "R9 chained value", act, model);
      eb = !((model % 16 == 0) && !downIn);
      ec = !((model % 16 == 15) && !upIn);
      check(loBorrowN == eb, "R6 borrow", loBorrowN, eb);
      check(loCarryN == ec, "R7 carry", loCarryN, ec);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit up, input bit dn, input int lowCycles);
    @(negedge clk); upIn = up ? 1'b0 : 1'b1; downIn = dn ? 1'b0 : 1'b1;
    idle(lowCycles);
    upIn = 1'b1; downIn = 1'b1;
    idle(4);
  endtask

  task automatic preset(input logic [7:0] v);
    @(negedge clk); dataByte = v; loadN = 1'b0;
    @(negedge clk); loadN = 1'b1;
    idle(1);
  endtask

  task automatic doClear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    idle(1);
  endtask

  task automatic expectByte(input int exp, input string req);
    #2;
    check({hiCount, loCount} == exp, req, {hiCount, loCount}, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual hung expected finish");
    finishRun();
  end

  initial begin
    idle(3);
    expectByte(0, "R5 reset state");
    clear = 1'b0;
    armed = 1'b1;
    idle(2);

    // R1: one up edge; exact latency
    @(negedge clk); upIn = 1'b0;
    @(negedge clk); upIn = 1'b1;
    idle(2); expectByte(0, "R1 not before third edge");
    idle(1); expectByte(1, "R1 step on third edge");
    idle(3);

    // R2, R3, R9: down through zero borrows from high stage
    pulse(1'b0, 1'b1, 4); expectByte(0, "R2 down step");
    pulse(1'b0, 1'b1, 4); expectByte(8'hFF, "R3 wrap down with borrow");

    // R10: a long low and a long high give one step only
    pulse(1'b1, 1'b0, 20); idle(16); expectByte(0, "R10 single step for held line");

    // R4: preset holds against an up edge inside the window
    @(negedge clk); dataByte = 8'h5A; loadN = 1'b0;
    @(negedge clk); upIn = 1'b0;
    @(negedge clk); upIn = 1'b1;
    idle(5); loadN = 1'b1;
    idle(4); expectByte(8'h5A, "R4 preset wins over count");

    // R3, R9: carry into high stage
    preset(8'h0F); pulse(1'b1, 1'b0, 4); expectByte(8'h10, "R3 wrap up with carry");

    // R8: simultaneous edges
    preset(8'h35); pulse(1'b1, 1'b1, 4); expectByte(8'h35, "R8 dual edge no change");

    // R5: clear is immediate and beats preset
    @(negedge clk); dataByte = 8'hC3; loadN = 1'b0; clear = 1'b1;
    #1; check({hiCount, loCount} == 0, "R5 immediate clear", {hiCount, loCount}, 0);
    @(negedge clk); clear = 1'b0; loadN = 1'b1;
    idle(2);

    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4)       pulse(1'b1, 1'b0, $urandom_range(1, 4));
      else if (op < 8)  pulse(1'b0, 1'b1, $urandom_range(1, 4));
      else if (op == 8) begin
        if ($urandom_range(0, 3) == 0) doClear();
        else preset(8'($urandom_range(0, 255)));
      end else          pulse(1'b1, 1'b1, 2);
    end
    idle(4);
    finishRun();
  end
endmodule